// File: doc/BRIEF.md
# Adaptive Second-Order Generalized Integrator Filter

This block is a sampled-data second-order generalized integrator. It runs on one clock domain and takes one signed sample per accepted input. From two integrator states it produces three results for every sample: a band-pass output that follows the input near the centre frequency, an output in quadrature with it, and an error output that has a notch at the centre frequency.

The centre frequency arrives on a port with every sample, as a per-sample angle step. A surrounding frequency estimator can therefore retune the notch on any sample, and no coefficient needs to be recomputed. The damping gain sits in a register. That register resets to 1.0 and is written through a load strobe.

In continuous-time terms the three paths approximate k·w·s/D(s), k·w²/D(s) and (s²+w²)/D(s), with D(s) = s² + k·w·s + w².

Top module: `sogi_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, both integrator states and all three outputs become 0 and `out_valid` becomes 0. The gain register takes the value 64, which is 1.0 with 6 fraction bits.
- R2: When `k_load` is high at a clock edge, `k_value` is written into the gain register. `k_value` is unsigned with 6 fraction bits. A sample accepted at the same edge still uses the previous gain. When `k_load` is low, the gain is unchanged.
- R3: For each accepted sample the state update is exact integer arithmetic, and every `>>>` is a floor shift. Let b and q be the states, x the sample, w the step and k the gain. Then e = x − b and d = ((e·k) >>> 6) − q. The new band-pass state is b' = clamp(b + ((d·w) >>> 16)). The new quadrature state is q' = clamp(q + ((b'·w) >>> 16)).
- R4: The outputs are registered one cycle after the accepted sample, and `out_valid` is high for exactly that cycle. The outputs are `y_err` = sat16(e), `y_bp` = sat16(b') and `y_q` = sat16(q'). sat16 clamps to the range −32768..32767.
- R5: In a cycle with `in_valid` low, the states and all three outputs hold, and `out_valid` is 0 in the following cycle.
- R6: Both states are 20-bit signed values: 4 guard bits above the 16-bit sample scale. On overflow they clamp to −524288 or 524287 and never wrap.
- R7: Each sample uses the `wstep` value presented with it. `wstep` is unsigned, equals w·Ts·2^16, and may differ on every sample.
- R8: Hold `wstep` = 6434 and the gain at 1.0. Feed x(n) = round(8000·sin(θn)), where θ = 2·asin(wstep/2^17). Then from sample 400 onward, |y_err| < 80, which is 1% of the amplitude.
- R9: Under the same conditions as R8, from sample 400 onward y_q(n) stays within 240 of −8000·cos(θ(n+1.5)). In other words, y_q lags the band-pass path by a quarter period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe; x_in and wstep are taken when high |
| x_in | input | 16 | Signed input sample |
| wstep | input | 16 | Unsigned centre-frequency step per sample, 16 fraction bits |
| k_load | input | 1 | Write strobe for the gain register |
| k_value | input | 8 | Unsigned gain, 6 fraction bits |
| out_valid | output | 1 | High for one cycle when new results are present |
| y_err | output | 16 | Notch (error) output |
| y_bp | output | 16 | Band-pass output |
| y_q | output | 16 | Quadrature output |

## Verification
The assertions check several properties on every cycle:
- The states never wrap: a non-negative increment never lowers a state, and a negative one never raises it.
- The states, outputs and gain hold across idle cycles.
- Every accepted sample produces exactly one valid cycle.
- The band-pass state reaches `y_bp` unchanged whenever it fits the output width.

Other behaviours show only in the bench's scenarios against an independent model:
- the exact arithmetic of the recurrence;
- the ordering of a gain load against a sample in the same cycle;
- per-sample retuning;
- deep saturation with a large step and gain;
- the notch depth and the quadrature phase after convergence.

// File: rtl/sogi_pkg.sv
// Package: shared definitions for the generalized-integrator filter.
// Assumes: the output index order below is used by the top-level output stage.
package sogi_pkg;
    typedef enum int {
        OUT_ERR = 0,
        OUT_BP  = 1,
        OUT_Q   = 2
    } sogi_out_e;

    localparam int NUM_OUT = 3;
endpackage

// File: rtl/sogi_sat.sv
// Module: sogi_sat
// Narrows a signed value to OUT_W bits and clamps it to the range of OUT_W.
// Assumes: IN_W > OUT_W. The module is purely combinational.
module sogi_sat #(
    parameter int IN_W  = 21,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int EXT_W = IN_W - OUT_W + 1;
    localparam logic signed [IN_W-1:0] HI = {{EXT_W{1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] LO = {{EXT_W{1'b1}}, {(OUT_W-1){1'b0}}};

    // Clamp to the narrow range, or pass the low bits when the value fits.
    always_comb begin
        if (din > HI)      dout = HI[OUT_W-1:0];
        else if (din < LO) dout = LO[OUT_W-1:0];
        else               dout = din[OUT_W-1:0];
    end
endmodule

// File: rtl/sogi_integ.sv
// Module: sogi_integ
// A single discrete integrator stage. On each enabled clock edge it does
//     state <= clamp(state + ((drive * wstep) >>> W_FRAC))
// wstep is unsigned. The clamped next value is also output combinationally,
// so a following stage can use it in the same sample.
// Assumes: the state width already includes the guard bits chosen by the parent.
module sogi_integ #(
    parameter int IN_W   = 31,
    parameter int ST_W   = 20,
    parameter int W_W    = 16,
    parameter int W_FRAC = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic signed [IN_W-1:0] drive,
    input  logic        [W_W-1:0]  wstep,
    output logic signed [ST_W-1:0] state,
    output logic signed [ST_W-1:0] nxt
);
    localparam int PR_W  = IN_W + W_W + 1;
    localparam int SUM_W = ((PR_W > ST_W) ? PR_W : ST_W) + 1;

    logic signed [PR_W-1:0]  prod;
    logic signed [PR_W-1:0]  inc;
    logic signed [SUM_W-1:0] sum;

    // Scale the drive by the frequency step and add the increment to the state.
    always_comb begin
        prod = drive * $signed({1'b0, wstep});
        inc  = prod >>> W_FRAC;
        sum  = SUM_W'(inc) + SUM_W'(state);
    end

    sogi_sat #(.IN_W(SUM_W), .OUT_W(ST_W)) u_sat (.din(sum), .dout(nxt));

    // Register the state. It changes only when a sample is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)  state <= '0;
        else if (en) state <= nxt;
    end

    // R6: a clamped add never moves the state against the sign of the increment.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !inc[PR_W-1]) |=> (state >= $past(state)));
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && inc[PR_W-1]) |=> (state <= $past(state)));
    // R5: no enable, no state change.
    assert_state_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state));
endmodule

// File: rtl/sogi_filter.sv
// Module: sogi_filter (top)
// Adaptive second-order generalized integrator. Two sogi_integ stages form
// the loop:
//     err = x - bp
//     bp' = bp + w*(k*err - q)
//     q'  = q + w*bp'
// The second stage uses the band-pass value just updated in the same sample.
// The notch, band-pass and quadrature results are registered one cycle after
// each accepted sample.
// Assumes: wstep is much smaller than 2^17, which keeps the discrete loop stable.
// The gain is loaded through k_load.
module sogi_filter
    import sogi_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 4,
    parameter int W_W     = 16,
    parameter int W_FRAC  = 16,
    parameter int K_W     = 8,
    parameter int K_FRAC  = 6,
    parameter int K_RESET = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic        [W_W-1:0]    wstep,
    input  logic                     k_load,
    input  logic        [K_W-1:0]    k_value,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] y_err,
    output logic signed [DATA_W-1:0] y_bp,
    output logic signed [DATA_W-1:0] y_q
);
    localparam int ST_W = DATA_W + GUARD_W;
    localparam int E_W  = ST_W + 1;
    localparam int KE_W = E_W + K_W + 1;
    localparam int D_W  = KE_W + 1;
    localparam logic signed [ST_W-1:0] FIT_HI = {{(GUARD_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ST_W-1:0] FIT_LO = {{(GUARD_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic        [K_W-1:0]    k_reg;
    logic signed [ST_W-1:0]   bp_state, bp_next, q_state, q_next;
    logic signed [E_W-1:0]    err_w;
    logic signed [KE_W-1:0]   ke_full, ke;
    logic signed [D_W-1:0]    drive_bp;
    logic signed [E_W-1:0]    sat_in  [NUM_OUT];
    logic signed [DATA_W-1:0] sat_out [NUM_OUT];

    // Gain register: written by the load strobe, reset to unity.
    always_ff @(posedge clk) begin
        if (!rst_n)      k_reg <= K_WIDTH_RESET;
        else if (k_load) k_reg <= k_value;
    end
    localparam logic [K_W-1:0] K_WIDTH_RESET = K_W'(K_RESET);

    // Form the error, the gain-scaled error and the drive of the first integrator.
    always_comb begin
        err_w    = E_W'(x_in) - E_W'(bp_state);
        ke_full  = err_w * $signed({1'b0, k_reg});
        ke       = ke_full >>> K_FRAC;
        drive_bp = D_W'(ke) - D_W'(q_state);
    end

    sogi_integ #(.IN_W(D_W), .ST_W(ST_W), .W_W(W_W), .W_FRAC(W_FRAC)) u_int_bp (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .drive(drive_bp),
        .wstep(wstep), .state(bp_state), .nxt(bp_next));

    sogi_integ #(.IN_W(ST_W), .ST_W(ST_W), .W_W(W_W), .W_FRAC(W_FRAC)) u_int_q (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .drive(bp_next),
        .wstep(wstep), .state(q_state), .nxt(q_next));

    // Collect the three results, widened to a common width for the output clamps.
    always_comb begin
        sat_in[OUT_ERR] = err_w;
        sat_in[OUT_BP]  = E_W'(bp_next);
        sat_in[OUT_Q]   = E_W'(q_next);
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out_sat
        sogi_sat #(.IN_W(E_W), .OUT_W(DATA_W)) u_osat (.din(sat_in[g]), .dout(sat_out[g]));
    end

    // Output registers and the one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y_err     <= '0;
            y_bp      <= '0;
            y_q       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                y_err <= sat_out[OUT_ERR];
                y_bp  <= sat_out[OUT_BP];
                y_q   <= sat_out[OUT_Q];
            end
        end
    end

    // R4: every accepted sample yields a valid cycle.
    assert_result_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R4: an in-range band-pass state reaches the output unchanged.
    assert_bp_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bp_next <= FIT_HI && bp_next >= FIT_LO)
        |=> (y_bp == $past(bp_next[DATA_W-1:0])));
    // R5: an idle cycle gives no valid pulse and keeps the outputs.
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(y_err) && $stable(y_bp) && $stable(y_q)));
    // R2: the gain changes only on a load.
    assert_gain_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !k_load |=> $stable(k_reg));
endmodule

// File: tb/tb_sogi_filter.sv
`timescale 1ns/1ps
// Scoreboard bench. The driver computes each expected result with an
// independent integer model of R3/R4 and queues it. The monitor pops an item
// on every out_valid and compares it with the outputs.
module tb_sogi_filter;
    localparam int  ST_MAX = 524287;
    localparam int  ST_MIN = -524288;
    localparam real AMP    = 8000.0;

    typedef struct {
        longint e, b, q;
        bit     chk;
        longint qref;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, k_load = 1'b0;
    logic signed [15:0] x_in = '0;
    logic [15:0] wstep = '0;
    logic [7:0]  k_value = '0;
    logic out_valid;
    logic signed [15:0] y_err, y_bp, y_q;

    int n_vec = 0, n_bad = 0;
    bit finished = 1'b0;
    exp_t sb[$];
    longint m_b = 0, m_q = 0, m_k = 64;
    longint last_e = 0, last_b = 0, last_q = 0;

    always #2.5 clk = ~clk;

    sogi_filter dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
        .wstep(wstep), .k_load(k_load), .k_value(k_value), .out_valid(out_valid),
        .y_err(y_err), .y_bp(y_bp), .y_q(y_q));

    function automatic longint clampv(longint v, longint lo, longint hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one sample and queue its expected result (R3, R4, R7; R2 load ordering).
    task automatic send(longint xv, longint wv, bit kl, longint kv, bit chk, longint qref);
        exp_t it;
        longint e, d, bn, qn;
        @(posedge clk); #1;
        in_valid = 1'b1; x_in = 16'(xv); wstep = 16'(wv);
        k_load = kl; k_value = 8'(kv);
        e  = xv - m_b;
        d  = ((e * m_k) >>> 6) - m_q;
        bn = clampv(m_b + ((d * wv) >>> 16), ST_MIN, ST_MAX);
        qn = clampv(m_q + ((bn * wv) >>> 16), ST_MIN, ST_MAX);
        m_b = bn; m_q = qn;
        if (kl) m_k = kv;
        it.e = clampv(e, -32768, 32767);
        it.b = clampv(bn, -32768, 32767);
        it.q = clampv(qn, -32768, 32767);
        it.chk = chk; it.qref = qref;
        last_e = it.e; last_b = it.b; last_q = it.q;
        sb.push_back(it);
    endtask

    // One idle cycle, optionally loading a gain, then check that nothing moved (R5).
    task automatic idle_check(bit kl, longint kv);
        @(posedge clk); #1;
        in_valid = 1'b0; k_load = kl; k_value = 8'(kv);
        if (kl) m_k = kv;
        @(posedge clk); #1;
        k_load = 1'b0;
        check(out_valid == 1'b0, "R5 valid low after idle", longint'(out_valid), 0);
        check(y_err == last_e && y_bp == last_b && y_q == last_q, "R5 outputs held",
              longint'(y_bp), last_b);
    endtask

    // Monitor: compare each valid result with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            if (sb.size() == 0) begin
                check(1'b0, "R4 unexpected valid", 1, 0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                check(longint'(y_err) == it.e, "R3 y_err", longint'(y_err), it.e);
                check(longint'(y_bp)  == it.b, "R3 y_bp",  longint'(y_bp),  it.b);
                check(longint'(y_q)   == it.q, "R3 y_q",   longint'(y_q),   it.q);
                if (it.chk) begin
                    check(y_err < 80 && y_err > -80, "R8 notch depth", longint'(y_err), 0);
                    check((longint'(y_q) - it.qref) < 240 && (it.qref - longint'(y_q)) < 240,
                          "R9 quadrature", longint'(y_q), it.qref);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        automatic real th = 2.0 * $asin(6434.0 / 131072.0);
        automatic logic [31:0] lfsr = 32'h1ACE_B00C;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
        check(y_err == 0 && y_bp == 0 && y_q == 0, "R1 outputs zero", longint'(y_bp), 0);
        rst_n = 1'b1;
        // R8/R9: tuned sinusoid, unity gain, converge and test notch and quadrature
        for (int n = 0; n < 500; n++) begin
            automatic real v = AMP * $sin(th * n);
            automatic real c = -AMP * $cos(th * (n + 1.5));
            automatic longint xv = longint'($rtoi(v + ((v >= 0.0) ? 0.5 : -0.5)));
            automatic longint qr = longint'($rtoi(c));
            send(xv, 6434, 1'b0, 0, n >= 400, qr);
            if (n == 250) idle_check(1'b0, 0);
        end
        // R2: gain load in the same cycle as a sample, then a load while idle
        send(1000, 6434, 1'b1, 32, 1'b0, 0);
        for (int n = 0; n < 60; n++) send(longint'(n * 300) - 9000, 6434, 1'b0, 0, 1'b0, 0);
        idle_check(1'b1, 160);
        for (int n = 0; n < 60; n++) send(4000, 9000, 1'b0, 0, 1'b0, 0);
        // R7: a new frequency step and a new sample on every cycle
        for (int n = 0; n < 200; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            send(longint'($signed(lfsr[15:0])) >>> 1, 1000 + longint'(lfsr[30:16] % 20000),
                 1'b0, 0, 1'b0, 0);
        end
        // R6: large step and gain drive the states into their clamps
        send(0, 60000, 1'b1, 255, 1'b0, 0);
        for (int n = 0; n < 40; n++) send(32767, 60000, 1'b0, 0, 1'b0, 0);
        for (int n = 0; n < 40; n++) send(-32768, 60000, 1'b0, 0, 1'b0, 0);
        idle_check(1'b0, 0);
        repeat (4) @(posedge clk);
        #1;
        check(sb.size() == 0, "R4 all results delivered", longint'(sb.size()), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule